// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A behavioural, synthesizable synchronous static RAM for a bench or an FPGA. Every input is captured on the rising clock edge. This covers the address, the write data, the three chip enables, two burst-start strobes, the advance control, the write enables and the burst-order select. The array is accessed one edge after capture. Read data then sits in an output register, next to a drive-enable flag that stands in for the enable of a shared data bus.

A burst begins when either start strobe loads the external address. After that, a 2-bit counter steps each time the active-low advance input is low. The low two address bits follow either a linear or an interleaved sequence, and the upper bits stay fixed. A write touches only the byte lanes whose active-low selects are low, and only while the lane-write enable is low. The global write instead writes every lane. The word is `BYTES` lanes of `BYTE_W` bits: four lanes of 9 bits give 36 bits, and two lanes give 18 bits.

Top module: `burst_sram`

## Requirements
- R1: After reset `drive_en_o` is 0 and `rdata_o` is 0. No burst is active, so advance cycles without a start strobe perform no access and `drive_en_o` stays 0.
- R2: A read captured at edge k loads `rdata_o` and sets `drive_en_o` at edge k+1. `rdata_o` holds its value in every cycle that performs no read.
- R3: With `order_ilv_i` = 0 the low two address bits are (start + count) mod 4. The count is 0 at the start and rises by one at each captured cycle of an active burst with `step_n_i` low. Upper address bits keep their start value.
- R4: With `order_ilv_i` = 1 the low two address bits are start XOR count.
- R5: With `wr_all_n_i` high and `lane_wr_en_n_i` low, byte lane i (bits 9i+8..9i) is written exactly when bit i of `lane_sel_n_i` is 0, and the other lanes keep their contents. With both write enables high, or with no lane selected, the cycle is a read.
- R6: `wr_all_n_i` low writes all lanes, whatever `lane_wr_en_n_i` and `lane_sel_n_i` are.
- R7: `host_strobe_n_i` low while selected starts a read burst at `addr_i`, even when write enables are low. It takes priority over `ctl_strobe_n_i`.
- R8: The device is selected when `en_a_n_i` = 0, `en_b_i` = 1 and `en_c_n_i` = 0. `ctl_strobe_n_i` low while not selected ends the burst within that single cycle: `drive_en_o` is 0 after the next edge, and later advance cycles perform nothing until a new start.
- R9: `host_strobe_n_i` low while not selected is ignored, and an active burst continues as a normal advance cycle.
- R10: `drive_en_o` is 0 after the edge that completes a write.
- R11: A read driven in the cycle right after a write to the same word returns the newly written data.
- R12: A continuation cycle with `step_n_i` high accesses the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Word address loaded at a burst start |
| en_a_n_i | input | 1 | Chip enable, active low |
| en_b_i | input | 1 | Chip enable, active high |
| en_c_n_i | input | 1 | Chip enable, active low |
| host_strobe_n_i | input | 1 | Read-only burst start, sampled only while selected, high priority |
| ctl_strobe_n_i | input | 1 | Burst start (read or write); deselects when not selected |
| step_n_i | input | 1 | Burst counter advance, active low |
| wr_all_n_i | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n_i | input | 1 | Qualifier for per-lane writes, active low |
| lane_sel_n_i | input | BYTES | Per-lane write selects, active low |
| order_ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata_i | input | BYTES*BYTE_W | Write data |
| rdata_o | output | BYTES*BYTE_W | Registered read data |
| drive_en_o | output | 1 | High when rdata_o holds the result of the last cycle's read |

## Verification
A read result is due two rising edges after the inputs are driven. The first edge captures the inputs and the second loads the output register. The drive-enable flag follows the same timing for reads, writes and deselects. A write changes the array at that same second edge, so a read driven one cycle later already sees it. The bench keeps one decoded operation in flight and checks it at the falling edge after the edge that completes it, so each result is compared exactly one step after its own stimulus.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of a burst beat: linear sum or interleaved xor.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    logic [1:0] res;
    if (ilv) res = start ^ cnt;
    else     res = start + cnt;
    return res;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 8,
  parameter int W      = 9
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_a_n_i,
  input  logic              en_b_i,
  input  logic              en_c_n_i,
  input  logic              host_strobe_n_i,
  input  logic              ctl_strobe_n_i,
  input  logic              step_n_i,
  input  logic              wr_all_n_i,
  input  logic              lane_wr_en_n_i,
  input  logic [BYTES-1:0]  lane_sel_n_i,
  input  logic              order_ilv_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [1:0]        cnt_o,
  output logic              ilv_o,
  output logic [BYTES-1:0]  mask_o
);

  logic              sel;
  logic              host_go;
  logic              ctl_go;
  logic [BYTES-1:0]  wmask;
  logic              is_wr;

  logic              act_q, act_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q;
  logic              base_ld;
  op_e               op_q, op_d;
  logic [BYTES-1:0]  mask_q, mask_d;
  logic              ilv_q;

  // Decode of the captured-edge inputs.
  always_comb begin
    sel     = !en_a_n_i && en_b_i && !en_c_n_i;
    host_go = !host_strobe_n_i && sel;
    ctl_go  = !ctl_strobe_n_i;
    if (!wr_all_n_i)          wmask = '1;
    else if (!lane_wr_en_n_i) wmask = ~lane_sel_n_i;
    else                      wmask = '0;
    is_wr = |wmask;
  end

  // Next-state logic.
  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    op_d    = OP_IDLE;
    mask_d  = '0;
    base_ld = 1'b0;
    if (host_go) begin
      act_d   = 1'b1;
      cnt_d   = 2'd0;
      base_ld = 1'b1;
      op_d    = OP_READ;
    end else if (ctl_go) begin
      if (sel) begin
        act_d   = 1'b1;
        cnt_d   = 2'd0;
        base_ld = 1'b1;
        op_d    = is_wr ? OP_WRITE : OP_READ;
        mask_d  = wmask;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      if (!step_n_i) cnt_d = cnt_q + 2'd1;
      op_d   = is_wr ? OP_WRITE : OP_READ;
      mask_d = wmask;
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= 2'd0;
      op_q   <= OP_IDLE;
      mask_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      mask_q <= mask_d;
      ilv_q  <= order_ilv_i;
    end
  end

  // Start address, loaded only at a burst start.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      base_q <= '0;
    else if (base_ld) base_q <= addr_i;
  end

  assign op_o   = op_q;
  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign ilv_o  = ilv_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    en_a_n_i,
  input  logic                    en_b_i,
  input  logic                    en_c_n_i,
  input  logic                    host_strobe_n_i,
  input  logic                    ctl_strobe_n_i,
  input  logic                    step_n_i,
  input  logic                    wr_all_n_i,
  input  logic                    lane_wr_en_n_i,
  input  logic [BYTES-1:0]        lane_sel_n_i,
  input  logic                    order_ilv_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    drive_en_o
);

  localparam int DW = BYTES * BYTE_W;

  logic              srst_n;
  op_e               op;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              ilv;
  logic [BYTES-1:0]  mask;
  logic [ADDR_W-1:0] eff_addr;
  logic [BYTES-1:0]  lane_we;
  logic              wdata_ce;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rd_word;
  logic [DW-1:0]     rdata_q;
  logic              drive_q;

  rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  burst_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk             (clk),
    .srst_n          (srst_n),
    .addr_i          (addr_i),
    .en_a_n_i        (en_a_n_i),
    .en_b_i          (en_b_i),
    .en_c_n_i        (en_c_n_i),
    .host_strobe_n_i (host_strobe_n_i),
    .ctl_strobe_n_i  (ctl_strobe_n_i),
    .step_n_i        (step_n_i),
    .wr_all_n_i      (wr_all_n_i),
    .lane_wr_en_n_i  (lane_wr_en_n_i),
    .lane_sel_n_i    (lane_sel_n_i),
    .order_ilv_i     (order_ilv_i),
    .op_o            (op),
    .base_o          (base),
    .cnt_o           (cnt),
    .ilv_o           (ilv),
    .mask_o          (mask)
  );

  // Beat address from the captured start address and counter.
  always_comb begin
    eff_addr      = base;
    eff_addr[1:0] = beat_low(base[1:0], cnt, ilv);
    lane_we       = (op == OP_WRITE) ? mask : '0;
  end

  // Write data capture, enabled only when a write is requested.
  assign wdata_ce = !wr_all_n_i || !lane_wr_en_n_i;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       wdata_q <= '0;
    else if (wdata_ce) wdata_q <= wdata_i;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .W(BYTE_W)) u_lane (
      .clk     (clk),
      .we_i    (lane_we[i]),
      .addr_i  (eff_addr),
      .wdata_i (wdata_q[i*BYTE_W +: BYTE_W]),
      .rdata_o (rd_word[i*BYTE_W +: BYTE_W])
    );
  end

  // Output register and bus drive flag.
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) drive_q <= 1'b0;
    else         drive_q <= (op == OP_READ);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)              rdata_q <= '0;
    else if (op == OP_READ)   rdata_q <= rd_word;
  end

  assign rdata_o    = rdata_q;
  assign drive_en_o = drive_q;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          srst_n,
  input logic          en_a_n_i,
  input logic          en_b_i,
  input logic          en_c_n_i,
  input logic          host_strobe_n_i,
  input logic          ctl_strobe_n_i,
  input logic          step_n_i,
  input logic [1:0]    op,
  input logic [1:0]    cnt,
  input logic [DW-1:0] rdata_o,
  input logic          drive_en_o
);

  logic sel;
  assign sel = !en_a_n_i && en_b_i && !en_c_n_i;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!srst_n)
    (op == 2'd1) |=> drive_en_o);  // R2

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (op != 2'd1) |=> $stable(rdata_o));  // R2

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    (op == 2'd2) |=> !drive_en_o);  // R10

  AST_HOST_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (!host_strobe_n_i && sel) |=> (op == 2'd1 && cnt == 2'd0));  // R7

  AST_DESELECT: assert property (@(posedge clk) disable iff (!srst_n)
    (!ctl_strobe_n_i && !sel) |=> (op == 2'd0));  // R8

  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_strobe_n_i && (host_strobe_n_i || !sel) && step_n_i) |=> $stable(cnt));  // R12

endmodule

bind burst_sram burst_sram_chk #(.DW(BYTES*BYTE_W)) u_chk (
  .clk             (clk),
  .srst_n          (srst_n),
  .en_a_n_i        (en_a_n_i),
  .en_b_i          (en_b_i),
  .en_c_n_i        (en_c_n_i),
  .host_strobe_n_i (host_strobe_n_i),
  .ctl_strobe_n_i  (ctl_strobe_n_i),
  .step_n_i        (step_n_i),
  .op              (op),
  .cnt             (cnt),
  .rdata_o         (rdata_o),
  .drive_en_o      (drive_en_o)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;

  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          ena_n, enb, enc_n;
  logic          hs_n, cs_n, step_n;
  logic          wall_n, lwe_n;
  logic [NB-1:0] lsel_n;
  logic          ilv;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          drv;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u0 (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_i          (addr),
    .en_a_n_i        (ena_n),
    .en_b_i          (enb),
    .en_c_n_i        (enc_n),
    .host_strobe_n_i (hs_n),
    .ctl_strobe_n_i  (cs_n),
    .step_n_i        (step_n),
    .wr_all_n_i      (wall_n),
    .lane_wr_en_n_i  (lwe_n),
    .lane_sel_n_i    (lsel_n),
    .order_ilv_i     (ilv),
    .wdata_i         (wdata),
    .rdata_o         (rdata),
    .drive_en_o      (drv)
  );

  // Reference state
  logic [DW-1:0] refm [DEPTH];
  logic          m_act;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  int            p_op;      // 0 idle, 1 read, 2 write
  logic [AW-1:0] p_addr;
  logic [NB-1:0] p_mask;
  logic [DW-1:0] p_data;
  string         p_req;

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_idle();
    ena_n = 1'b0; enb = 1'b1; enc_n = 1'b0;
    hs_n = 1'b1; cs_n = 1'b1; step_n = 1'b1;
    wall_n = 1'b1; lwe_n = 1'b1; lsel_n = '1;
    ilv = 1'b0; addr = '0; wdata = '0;
  endtask

  // One clock: decode the driven inputs per the requirements, then
  // check the operation completed at the edge just passed.
  task automatic tick(input string req);
    bit            sel;
    logic [NB-1:0] wm;
    int            op;
    logic [1:0]    lo;
    logic [AW-1:0] a;
    sel = !ena_n && enb && !enc_n;
    if (!wall_n)     wm = '1;
    else if (!lwe_n) wm = ~lsel_n;
    else             wm = '0;
    op = 0;
    if (!hs_n && sel) begin
      m_act = 1'b1; m_base = addr; m_cnt = 2'd0; op = 1;
    end else if (!cs_n) begin
      if (sel) begin
        m_act = 1'b1; m_base = addr; m_cnt = 2'd0; op = (wm != 0) ? 2 : 1;
      end else begin
        m_act = 1'b0;
      end
    end else if (m_act) begin
      if (!step_n) m_cnt = m_cnt + 2'd1;
      op = (wm != 0) ? 2 : 1;
    end
    lo = ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    a = {m_base[AW-1:2], lo};
    @(posedge clk);
    @(negedge clk);
    if (p_op == 2) begin
      for (int i = 0; i < NB; i++)
        if (p_mask[i]) refm[p_addr][i*BW +: BW] = p_data[i*BW +: BW];
      chk(drv == 1'b0, p_req, "drive after write", 64'(drv), 64'd0);
    end else if (p_op == 1) begin
      chk(drv == 1'b1, p_req, "drive after read", 64'(drv), 64'd1);
      chk(rdata == refm[p_addr], p_req, "read data", 64'(rdata), 64'(refm[p_addr]));
    end else begin
      chk(drv == 1'b0, p_req, "drive when idle", 64'(drv), 64'd0);
    end
    p_op = op; p_addr = a; p_mask = wm; p_data = wdata; p_req = req;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] keep;
    void'($urandom(32'd1234));
    set_idle();
    rst_n = 1'b0;
    m_act = 1'b0; m_base = '0; m_cnt = '0;
    p_op = 0; p_addr = '0; p_mask = '0; p_data = '0; p_req = "R1";
    repeat (3) @(negedge clk);
    chk(drv == 1'b0, "R1", "drive in reset", 64'(drv), 64'd0);
    chk(rdata == '0, "R1", "rdata in reset", 64'(rdata), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: advance with no burst started performs nothing
    step_n = 1'b0; wall_n = 1'b0;
    repeat (3) tick("R1");
    set_idle();

    // Fill the whole array with global-write linear bursts (R3, R6)
    for (int b = 0; b < DEPTH; b += 4) begin
      cs_n = 1'b0; addr = AW'(b); wall_n = 1'b0; wdata = rnd_word();
      tick("R6");
      cs_n = 1'b1; step_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
        wdata = rnd_word();
        tick("R3");
      end
      set_idle();
    end

    // Both burst orders from every starting offset, with wrap (R3, R4)
    for (int m = 0; m < 2; m++) begin
      for (int off = 0; off < 4; off++) begin
        set_idle();
        ilv = m[0]; cs_n = 1'b0; addr = AW'(8'h44 + off);
        tick(m ? "R4" : "R3");
        cs_n = 1'b1; step_n = 1'b0;
        for (int k = 0; k < 4; k++) tick(m ? "R4" : "R3");
        step_n = 1'b1;
        tick("R12");
      end
    end

    // Every lane mask, then back-to-back read of the same word (R5, R11)
    for (int mk = 0; mk < 16; mk++) begin
      set_idle();
      cs_n = 1'b0; addr = AW'(8'h80 + mk); lwe_n = 1'b0; lsel_n = ~mk[NB-1:0];
      wdata = rnd_word();
      tick("R5");
      set_idle();
      cs_n = 1'b0; addr = AW'(8'h80 + mk);
      tick("R11");
    end
    // Lane selects low but lane enable high: a read, nothing written (R5)
    set_idle();
    cs_n = 1'b0; addr = 8'h90; lsel_n = '0; wdata = rnd_word();
    tick("R5");
    set_idle(); cs_n = 1'b0; addr = 8'h90;
    tick("R5");

    // Global write beats lane controls (R6)
    set_idle();
    cs_n = 1'b0; addr = 8'h91; wall_n = 1'b0; lwe_n = 1'b1; lsel_n = '1;
    wdata = rnd_word();
    tick("R6");
    set_idle(); cs_n = 1'b0; addr = 8'h91;
    tick("R6");

    // Host strobe wins over controller strobe and never writes (R7)
    set_idle();
    keep = refm[8'h92];
    hs_n = 1'b0; cs_n = 1'b0; addr = 8'h92; wall_n = 1'b0; wdata = ~keep;
    tick("R7");
    set_idle(); cs_n = 1'b0; addr = 8'h92;
    tick("R7");

    // Deselect through controller strobe, then advances do nothing (R8)
    set_idle(); cs_n = 1'b0; addr = 8'h10;
    tick("R8");
    set_idle(); cs_n = 1'b0; enb = 1'b0;
    tick("R8");
    set_idle(); step_n = 1'b0; wall_n = 1'b0; wdata = rnd_word();
    repeat (2) tick("R8");

    // Host strobe while unselected is ignored; burst continues (R9)
    set_idle(); cs_n = 1'b0; addr = 8'h21; ilv = 1'b1;
    tick("R9");
    set_idle(); ilv = 1'b1; hs_n = 1'b0; ena_n = 1'b1; step_n = 1'b0; addr = 8'hF0;
    tick("R9");
    set_idle(); ilv = 1'b1; step_n = 1'b0;
    tick("R9");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      ena_n  = ($urandom_range(0, 15) == 0);
      enb    = ($urandom_range(0, 15) != 0);
      enc_n  = ($urandom_range(0, 15) == 0);
      hs_n   = ($urandom_range(0, 9) != 0);
      cs_n   = ($urandom_range(0, 5) != 0);
      step_n = $urandom_range(0, 1) == 1;
      wall_n = ($urandom_range(0, 7) != 0);
      lwe_n  = ($urandom_range(0, 3) != 0);
      lsel_n = NB'($urandom());
      ilv    = $urandom_range(0, 1) == 1;
      addr   = AW'($urandom());
      wdata  = rnd_word();
      tick("R2");
    end

    set_idle(); cs_n = 1'b0; enb = 1'b0;
    tick("R8");
    set_idle();
    repeat (2) tick("R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule